// File: doc/BRIEF.md
# Multi-Modulus Prescaler Count Calculator

This block turns a requested overall divide ratio for a fractional-N synthesizer feedback path into the number of divisions the prescaler must make by each of its moduli. The default set of moduli is 64, 65 and 72. A mode input selects a second set of 64, 65, 68 and 73. The ratio is first split into a base multiple of 64 and a remainder below 64. The remainder is then covered by the larger moduli, taking as many of the largest one as fit, and every larger division stands in for one divide-by-64.

A pulse on `start` captures the ratio and the mode. A fixed two edges later the block presents the counts, a valid flag and a dual-modulus fallback flag, and raises `done`. All of these hold until the next `start`. The divide-by-64 count is reported with the hardware bias of two already removed. A ratio whose divide-by-64 total falls outside the programmable range is flagged invalid, and all of its counts are zeroed. The block only works out register values. It does not run the prescaler.

Top module: `pmod_count_calc`

## Requirements
- R1: In three-modulus mode (`four_mode`=0), with D = ratio mod 64, `cnt72` = floor(D/8) and `cnt65` = D mod 8, while `cnt68` and `cnt73` are 0.
- R2: In three-modulus mode the total number of divide-by-64s is floor(ratio/64) − cnt65 − cnt72, and `cnt64` carries that total minus 2.
- R3: `dual` is 1 only for a valid three-modulus result with `cnt72` = 0. In four-modulus mode it is always 0.
- R4: `valid` is 1 exactly when the total number of divide-by-64s lies between 2 and 4097 inclusive.
- R5: When `valid` is 0, `cnt64`, `cnt65`, `cnt68`, `cnt72`, `cnt73` and `dual` are all 0.
- R6: In four-modulus mode (`four_mode`=1), `cnt73` = floor(D/9) and r = D mod 9. If r ≥ 4 then `cnt68` = 1 and `cnt65` = r − 4; otherwise `cnt68` = 0 and `cnt65` = r. `cnt72` is 0.
- R7: In four-modulus mode the total number of divide-by-64s is floor(ratio/64) − cnt65 − cnt68 − cnt73, and `cnt64` carries that total minus 2.
- R8: `done` is 0 after the clock edge that samples `start` high. It is 1 after the next edge (when `start` is then low), and it stays 1 until `start` is sampled again.
- R9: While `done` is high and `start` is low, every output holds its value, whatever `ratio` and `four_mode` do.
- R10: For a valid result, 64·(cnt64+2) + 65·cnt65 + 68·cnt68 + 72·cnt72 + 73·cnt73 equals the captured ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture `ratio` and `four_mode` and begin a calculation |
| four_mode | input | 1 | 0: moduli 64/65/72; 1: moduli 64/65/68/73 |
| ratio | input | 20 | Requested total divide ratio |
| cnt64 | output | 12 | Divide-by-64 count minus 2 |
| cnt65 | output | 3 | Divide-by-65 count |
| cnt68 | output | 1 | Divide-by-68 count |
| cnt72 | output | 3 | Divide-by-72 count |
| cnt73 | output | 3 | Divide-by-73 count |
| dual | output | 1 | Fall back to two-modulus operation |
| valid | output | 1 | Ratio can be reached within range |
| done | output | 1 | Result present and stable |

## Verification
The bench builds the block with its defaults: a 20-bit ratio, the four-modulus variant included, and a divide-by-64 range of 2 to 4097. The 20-bit ratio reaches both ends of that range and the ratios just beyond them. Those cases include the lowest legal total, the highest, and a large base whose remainder of 63 pulls the most divisions away from the 64 count. With four-modulus support built in, the same instance also covers both sides of the remainder-of-four threshold and the case where the dual flag must stay low.

// File: rtl/pmod_pkg.sv
package pmod_pkg;

    localparam int RATIO_W  = 20;
    localparam int FRAC_W   = 6;
    localparam int MIN64    = 2;
    localparam int MAX64    = 4097;
    localparam int SUM_W    = RATIO_W - FRAC_W + 2;
    localparam int CNT64_W  = $clog2(MAX64 - MIN64 + 1);
    localparam int SMALL_W  = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic signed [SUM_W-1:0] n64;
        logic [SMALL_W-1:0]      n65;
        logic                    n68;
        logic [SMALL_W-1:0]      n72;
        logic [SMALL_W-1:0]      n73;
        logic                    four;
    } split_t;

    function automatic logic signed [SUM_W-1:0] base_of(ratio_t r);
        return $signed(SUM_W'(r[RATIO_W-1:FRAC_W]));
    endfunction

    function automatic split_t split_three(ratio_t r);
        split_t s;
        logic [FRAC_W-1:0] d;
        d      = r[FRAC_W-1:0];
        s      = '0;
        s.n72  = d[FRAC_W-1:FRAC_W-SMALL_W];
        s.n65  = d[SMALL_W-1:0];
        s.n64  = base_of(r) - $signed(SUM_W'(s.n65)) - $signed(SUM_W'(s.n72));
        return s;
    endfunction

    function automatic split_t split_four(ratio_t r);
        split_t s;
        int     d;
        int     q;
        int     rm;
        d      = int'(r[FRAC_W-1:0]);
        q      = d / 9;
        rm     = d - 9 * q;
        s      = '0;
        s.four = 1'b1;
        s.n73  = SMALL_W'(q);
        if (rm >= 4) begin
            s.n68 = 1'b1;
            s.n65 = SMALL_W'(rm - 4);
        end else begin
            s.n68 = 1'b0;
            s.n65 = SMALL_W'(rm);
        end
        s.n64  = base_of(r) - $signed(SUM_W'(s.n65)) - $signed(SUM_W'(s.n68))
                 - $signed(SUM_W'(s.n73));
        return s;
    endfunction

endpackage

// File: rtl/pmod_split.sv
module pmod_split
    import pmod_pkg::*;
#(
    parameter bit FOUR_EN = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   four_mode,
    input  ratio_t ratio,
    output split_t split_q,
    output logic   pend_q
);

    split_t pick;

    generate
        if (FOUR_EN) begin : g_four
            always_comb pick = four_mode ? split_four(ratio) : split_three(ratio);
        end else begin : g_three
            always_comb pick = split_three(ratio);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            pend_q <= start;
            if (start) split_q <= pick;
        end
    end

endmodule

// File: rtl/pmod_range.sv
module pmod_range
    import pmod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               pend,
    input  split_t             split_in,
    output logic [CNT64_W-1:0] cnt64,
    output logic [SMALL_W-1:0] cnt65,
    output logic               cnt68,
    output logic [SMALL_W-1:0] cnt72,
    output logic [SMALL_W-1:0] cnt73,
    output logic               dual,
    output logic               valid,
    output logic               done
);

    localparam logic signed [SUM_W-1:0] LO = SUM_W'(MIN64);
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(MAX64);

    logic in_range;
    logic signed [SUM_W-1:0] biased;

    always_comb begin
        in_range = (split_in.n64 >= LO) && (split_in.n64 <= HI);
        biased   = split_in.n64 - LO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt64 <= '0;
            cnt65 <= '0;
            cnt68 <= 1'b0;
            cnt72 <= '0;
            cnt73 <= '0;
            dual  <= 1'b0;
            valid <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            done <= 1'b0;
        end else if (pend) begin
            done  <= 1'b1;
            valid <= in_range;
            if (in_range) begin
                cnt64 <= CNT64_W'(biased);
                cnt65 <= split_in.n65;
                cnt68 <= split_in.n68;
                cnt72 <= split_in.n72;
                cnt73 <= split_in.n73;
                dual  <= !split_in.four && (split_in.n72 == '0);
            end else begin
                cnt64 <= '0;
                cnt65 <= '0;
                cnt68 <= 1'b0;
                cnt72 <= '0;
                cnt73 <= '0;
                dual  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pmod_count_calc.sv
module pmod_count_calc
    import pmod_pkg::*;
#(
    parameter bit FOUR_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               four_mode,
    input  logic [RATIO_W-1:0] ratio,
    output logic [CNT64_W-1:0] cnt64,
    output logic [SMALL_W-1:0] cnt65,
    output logic               cnt68,
    output logic [SMALL_W-1:0] cnt72,
    output logic [SMALL_W-1:0] cnt73,
    output logic               dual,
    output logic               valid,
    output logic               done
);

    split_t split_q;
    logic   pend_q;

    pmod_split #(.FOUR_EN(FOUR_EN)) u_split (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .four_mode (four_mode),
        .ratio     (ratio),
        .split_q   (split_q),
        .pend_q    (pend_q)
    );

    pmod_range u_range (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pend     (pend_q),
        .split_in (split_q),
        .cnt64    (cnt64),
        .cnt65    (cnt65),
        .cnt68    (cnt68),
        .cnt72    (cnt72),
        .cnt73    (cnt73),
        .dual     (dual),
        .valid    (valid),
        .done     (done)
    );

endmodule

// File: rtl/pmod_count_calc_chk.sv
module pmod_count_calc_chk
    import pmod_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [RATIO_W-1:0] ratio,
    input logic [CNT64_W-1:0] cnt64,
    input logic [SMALL_W-1:0] cnt65,
    input logic               cnt68,
    input logic [SMALL_W-1:0] cnt72,
    input logic [SMALL_W-1:0] cnt73,
    input logic               dual,
    input logic               valid,
    input logic               done
);

    logic [RATIO_W-1:0] held_ratio;
    int unsigned        total;

    always_ff @(posedge clk) begin
        if (rst) held_ratio <= '0;
        else if (start) held_ratio <= ratio;
    end

    always_comb begin
        total = 64 * (int'(cnt64) + MIN64) + 65 * int'(cnt65) + 68 * int'(cnt68)
              + 72 * int'(cnt72) + 73 * int'(cnt73);
    end

    p_done_drop_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

    p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !start) |=> done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable({cnt64, cnt65, cnt68, cnt72, cnt73, dual, valid, done}));

    p_zero_invalid_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !valid) |-> ({cnt64, cnt65, cnt68, cnt72, cnt73, dual} == '0));

    p_dual_no72_r3: assert property (@(posedge clk) disable iff (rst)
        dual |-> (valid && cnt72 == '0 && !cnt68 && cnt73 == '0));

    p_sets_apart_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt72 != '0) |-> (!cnt68 && cnt73 == '0));

    p_sum_r10: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (total == int'(held_ratio)));

endmodule

bind pmod_count_calc pmod_count_calc_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ratio (ratio),
    .cnt64 (cnt64),
    .cnt65 (cnt65),
    .cnt68 (cnt68),
    .cnt72 (cnt72),
    .cnt73 (cnt73),
    .dual  (dual),
    .valid (valid),
    .done  (done)
);

// File: tb/sim_pmod_count_calc.sv
`timescale 1ns/1ps
module sim_pmod_count_calc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        four_mode = 1'b0;
    logic [19:0] ratio = '0;
    logic [11:0] cnt64;
    logic [2:0]  cnt65;
    logic        cnt68;
    logic [2:0]  cnt72;
    logic [2:0]  cnt73;
    logic        dual;
    logic        valid;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pmod_count_calc u0 (
        .clk(clk), .rst(rst), .start(start), .four_mode(four_mode), .ratio(ratio),
        .cnt64(cnt64), .cnt65(cnt65), .cnt68(cnt68), .cnt72(cnt72), .cnt73(cnt73),
        .dual(dual), .valid(valid), .done(done)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Run one calculation and compare against values derived from the requirements.
    task automatic run_case(input int r, input bit fm);
        int base, d, e64, e65, e68, e72, e73, tot64, q, rm;
        bit ok, edual;
        base = r / 64;
        d    = r % 64;
        e68 = 0; e72 = 0; e73 = 0;
        if (!fm) begin          // R1, R2
            e72 = d / 8;
            e65 = d % 8;
            tot64 = base - e65 - e72;
        end else begin          // R6, R7
            q  = d / 9;
            rm = d % 9;
            e73 = q;
            if (rm >= 4) begin e68 = 1; e65 = rm - 4; end
            else e65 = rm;
            tot64 = base - e65 - e68 - e73;
        end
        ok    = (tot64 >= 2) && (tot64 <= 4097);     // R4
        edual = ok && !fm && (e72 == 0);             // R3
        e64   = tot64 - 2;
        if (!ok) begin e64 = 0; e65 = 0; e68 = 0; e72 = 0; e73 = 0; end  // R5

        @(negedge clk);
        ratio = 20'(r); four_mode = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk($sformatf("R8 done low after start ratio=%0d", r), int'(done), 0);
        @(negedge clk);
        chk($sformatf("R8 done high ratio=%0d", r), int'(done), 1);
        chk($sformatf("R4 valid ratio=%0d", r), int'(valid), int'(ok));
        chk($sformatf("R2 R7 cnt64 ratio=%0d", r), int'(cnt64), e64);
        chk($sformatf("R1 R6 cnt65 ratio=%0d", r), int'(cnt65), e65);
        chk($sformatf("R6 cnt68 ratio=%0d", r), int'(cnt68), e68);
        chk($sformatf("R1 cnt72 ratio=%0d", r), int'(cnt72), e72);
        chk($sformatf("R6 cnt73 ratio=%0d", r), int'(cnt73), e73);
        chk($sformatf("R3 dual ratio=%0d", r), int'(dual), int'(edual));
        if (ok)
            chk($sformatf("R10 total ratio=%0d", r),
                64 * (int'(cnt64) + 2) + 65 * int'(cnt65) + 68 * int'(cnt68)
                + 72 * int'(cnt72) + 73 * int'(cnt73), r);
    endtask

    task automatic reset_state();
        @(negedge clk);
        chk("R8 reset done", int'(done), 0);
        chk("R5 reset valid", int'(valid), 0);
        chk("R5 reset counts", int'({cnt64, cnt65, cnt68, cnt72, cnt73, dual}), 0);
    endtask

    task automatic hold_test();
        logic [22:0] snap;
        run_case(1250, 1'b0);
        snap = {cnt64, cnt65, cnt68, cnt72, cnt73, dual, valid, done};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ratio = 20'(i * 7919 + 131);
            four_mode = i[0];
        end
        @(negedge clk);
        chk("R9 outputs held without start",
            int'({cnt64, cnt65, cnt68, cnt72, cnt73, dual, valid, done}), int'(snap));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        reset_state();
        run_case(1250, 1'b0);           // mixed remainder
        run_case(5000, 1'b0);           // one divide-by-72
        run_case(5001, 1'b0);
        run_case(640, 1'b0);            // zero remainder, dual
        run_case(130, 1'b0);            // below minimum
        run_case(128, 1'b0);            // minimum total
        run_case(64 * 4097, 1'b0);      // maximum total
        run_case(64 * 4098, 1'b0);      // above maximum
        run_case(64 * 4104 + 63, 1'b0); // remainder 63 on large base
        run_case(1250, 1'b1);           // four-modulus, remainder 7
        run_case(643, 1'b1);            // remainder 3
        run_case(64 * 10 + 13, 1'b1);   // remainder exactly 4
        run_case(64 * 10, 1'b1);        // dual stays low
        run_case(64 * 4104 + 63, 1'b1);
        hold_test();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

endmodule